// File: doc/BRIEF.md
# SD Host Command and Data Line Inhibit Logic

This block tracks whether an SD host controller may start a new command. It holds two busy flags. The CMD-line flag is set once a command has been accepted and stays set until the main response of that command arrives. The DAT-line flag is set while the data lines are in use, and software must wait for it before starting any command that needs them. The block also reports when the DAT signals are active, and it emits a one-cycle command-complete pulse when the CMD-line flag drops.

Each command-register write carries three attributes: the command uses the DAT lines, it has a busy-type response, or an automatic stop or block-count command goes with it. Every response strobe is tagged as coming from either an automatic command or the main command, and only the main response finishes the command. The logic checks each write against both flags and rejects a write that conflicts with them. If the issue engine reports an error strobe, the command counts as never issued: the CMD-line flag stays set and no completion pulse is produced. For busy-type responses the DAT-line flag holds until the synchronized DAT[0] level goes high again.

Top module: `sd_line_inhibit`

## Requirements
- R1: After synchronous reset, cmd_inhibit, dat_inhibit, dat_line_active, cmd_done and cmd_reject are all 0.
- R2: An accepted command write (cmd_wr high at a clock edge) makes cmd_inhibit 1 starting the next cycle.
- R3: A response strobe with rsp_is_auto=0, received while cmd_inhibit is 1, clears cmd_inhibit at that edge. cmd_done is 1 in the first cycle in which cmd_inhibit reads 0.
- R4: A response strobe with rsp_is_auto=1 never clears cmd_inhibit and never produces cmd_done.
- R5: An err_conflict or err_ac12_not_issued strobe while cmd_inhibit is 1 locks the block. After that, cmd_inhibit stays 1, later responses are ignored and no cmd_done is produced until reset.
- R6: A command write while cmd_inhibit is 1 is rejected. cmd_reject is 1 for the next cycle, and cmd_inhibit is unchanged.
- R7: A write with cmd_uses_dat=1 or cmd_busy_rsp=1 is rejected while dat_inhibit is 1. A write with both at 0 is accepted while dat_inhibit is 1, provided cmd_inhibit is 0.
- R8: dat_inhibit is 1 in any cycle where rd_xfer_active or dat_line_active is 1.
- R9: An accepted command that uses DAT holds dat_inhibit at 1 from the cycle after the write until its main response.
- R10: After the main response of a busy-type command, dat_inhibit and dat_line_active stay 1 until the synchronized DAT[0] reads high. With the default two synchronizer stages, they drop on the third clock edge after dat0_in rises.
- R11: dat_line_active is 1 whenever dat_io_active is 1 or a busy wait is in progress, and 0 otherwise.
- R12: cmd_done is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_uses_dat | input | 1 | Command transfers data on DAT lines |
| cmd_busy_rsp | input | 1 | Command has a busy-type response |
| cmd_has_auto | input | 1 | An automatic stop/count command accompanies this command |
| rsp_valid | input | 1 | Response received strobe |
| rsp_is_auto | input | 1 | Response belongs to the automatic command |
| err_conflict | input | 1 | Command conflict error strobe |
| err_ac12_not_issued | input | 1 | Command not issued due to auto-stop error strobe |
| dat0_in | input | 1 | Asynchronous DAT[0] level |
| rd_xfer_active | input | 1 | Read transfer in progress |
| dat_io_active | input | 1 | Data engine driving or sampling DAT lines |
| cmd_inhibit | output | 1 | CMD line busy; no new command may be issued |
| dat_inhibit | output | 1 | DAT line busy; no DAT command may be issued |
| dat_line_active | output | 1 | Activity on the DAT signals |
| cmd_done | output | 1 | One-cycle command-complete pulse |
| cmd_reject | output | 1 | One-cycle pulse for a rejected command write |

## Verification
A plain CMD-only command is run through a full write and response cycle, and then compared with a command that carries an automatic companion. This shows whether the auto-tagged response is wrongly treated as completion. Error strobes are sent before the main response so that a lock can be told apart from a normal clear. Write attempts are made under three conditions: while CMD is inhibited, while a read transfer holds DAT, and for a CMD-only command, which separates the two rejection rules. A busy-type command is observed with DAT[0] held low and then released, and the DAT flag is sampled edge by edge to pin down the synchronizer latency.

// File: rtl/sdli_pkg.sv
package sdli_pkg;

    typedef struct packed {
        logic uses_dat;
        logic busy_rsp;
        logic has_auto;
    } cmd_attr_t;

    typedef enum logic {
        BSY_IDLE = 1'b0,
        BSY_WAIT = 1'b1
    } busy_st_t;

    function automatic logic wr_allowed(input logic cmd_inh,
                                        input logic dat_inh,
                                        input logic uses_dat);
        return !cmd_inh && !(uses_dat && dat_inh);
    endfunction

endpackage

// File: rtl/sdli_sync.sv
module sdli_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdli_cmd_track.sv
module sdli_cmd_track
    import sdli_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_wr,
    input  cmd_attr_t attr_in,
    input  logic      dat_inh,
    input  logic      rsp_valid,
    input  logic      rsp_is_auto,
    input  logic      err_conflict,
    input  logic      err_ac12,
    output logic      cmd_inh,
    output logic      cmd_done,
    output logic      cmd_reject,
    output logic      accept,
    output logic      main_rsp_hit,
    output cmd_attr_t pend_attr
);
    logic inh_q, lock_q, done_q, rej_q;
    logic err_hit;
    cmd_attr_t attr_q;

    assign accept       = cmd_wr && wr_allowed(inh_q, dat_inh, attr_in.uses_dat);
    assign err_hit      = (err_conflict || err_ac12) && inh_q && !lock_q;
    assign main_rsp_hit = rsp_valid && !rsp_is_auto && inh_q && !lock_q && !err_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            inh_q  <= 1'b0;
            lock_q <= 1'b0;
            done_q <= 1'b0;
            rej_q  <= 1'b0;
            attr_q <= '0;
        end else begin
            if (accept)            inh_q <= 1'b1;
            else if (main_rsp_hit) inh_q <= 1'b0;
            if (err_hit)           lock_q <= 1'b1;
            if (accept)            attr_q <= attr_in;
            done_q <= main_rsp_hit;
            rej_q  <= cmd_wr && !accept;
        end
    end

    assign cmd_inh    = inh_q;
    assign cmd_done   = done_q;
    assign cmd_reject = rej_q;
    assign pend_attr  = attr_q;

    AST_SET_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        accept |=> cmd_inh); // R2
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> $fell(cmd_inh)); // R3
    AST_AUTO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (cmd_inh && rsp_valid && rsp_is_auto) |=> (cmd_inh && !cmd_done)); // R4
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> (cmd_inh && !cmd_done)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done); // R12
endmodule

// File: rtl/sdli_dat_track.sv
module sdli_dat_track
    import sdli_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  cmd_attr_t attr_in,
    input  logic      main_rsp_hit,
    input  cmd_attr_t pend_attr,
    input  logic      dat0_s,
    input  logic      rd_xfer_active,
    input  logic      dat_io_active,
    output logic      dat_inh,
    output logic      dat_line_active
);
    logic     pend_q;
    busy_st_t bst_q, bst_d;

    always_comb begin
        bst_d = bst_q;
        case (bst_q)
            BSY_IDLE: if (main_rsp_hit && pend_attr.busy_rsp) bst_d = BSY_WAIT;
            BSY_WAIT: if (dat0_s) bst_d = BSY_IDLE;
            default:  bst_d = BSY_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            bst_q  <= BSY_IDLE;
        end else begin
            if (accept && attr_in.uses_dat) pend_q <= 1'b1;
            else if (main_rsp_hit)          pend_q <= 1'b0;
            bst_q <= bst_d;
        end
    end

    assign dat_line_active = dat_io_active || (bst_q == BSY_WAIT);
    assign dat_inh         = pend_q || dat_line_active || rd_xfer_active;

    AST_PEND_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (accept && attr_in.uses_dat) |=> dat_inh); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((bst_q == BSY_WAIT) && !dat0_s) |=> (dat_inh && dat_line_active)); // R10
    AST_RD_COVERS: assert property (@(posedge clk) disable iff (rst)
        rd_xfer_active |-> dat_inh); // R8
endmodule

// File: rtl/sd_line_inhibit.sv
module sd_line_inhibit
    import sdli_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic cmd_uses_dat,
    input  logic cmd_busy_rsp,
    input  logic cmd_has_auto,
    input  logic rsp_valid,
    input  logic rsp_is_auto,
    input  logic err_conflict,
    input  logic err_ac12_not_issued,
    input  logic dat0_in,
    input  logic rd_xfer_active,
    input  logic dat_io_active,
    output logic cmd_inhibit,
    output logic dat_inhibit,
    output logic dat_line_active,
    output logic cmd_done,
    output logic cmd_reject
);
    cmd_attr_t attr_in, pend_attr;
    logic      accept, main_rsp_hit, dat0_s;

    always_comb begin
        attr_in.uses_dat = cmd_uses_dat || cmd_busy_rsp;
        attr_in.busy_rsp = cmd_busy_rsp;
        attr_in.has_auto = cmd_has_auto;
    end

    sdli_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (dat0_in),
        .q   (dat0_s)
    );

    sdli_cmd_track u_cmd (
        .clk          (clk),
        .rst          (rst),
        .cmd_wr       (cmd_wr),
        .attr_in      (attr_in),
        .dat_inh      (dat_inhibit),
        .rsp_valid    (rsp_valid),
        .rsp_is_auto  (rsp_is_auto),
        .err_conflict (err_conflict),
        .err_ac12     (err_ac12_not_issued),
        .cmd_inh      (cmd_inhibit),
        .cmd_done     (cmd_done),
        .cmd_reject   (cmd_reject),
        .accept       (accept),
        .main_rsp_hit (main_rsp_hit),
        .pend_attr    (pend_attr)
    );

    sdli_dat_track u_dat (
        .clk             (clk),
        .rst             (rst),
        .accept          (accept),
        .attr_in         (attr_in),
        .main_rsp_hit    (main_rsp_hit),
        .pend_attr       (pend_attr),
        .dat0_s          (dat0_s),
        .rd_xfer_active  (rd_xfer_active),
        .dat_io_active   (dat_io_active),
        .dat_inh         (dat_inhibit),
        .dat_line_active (dat_line_active)
    );

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_inhibit) |=> (cmd_reject && cmd_inhibit)); // R6
    AST_DAT_REJECT: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && (cmd_uses_dat || cmd_busy_rsp) && dat_inhibit) |=> cmd_reject); // R7
    AST_IO_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        dat_io_active |-> (dat_line_active && dat_inhibit)); // R11
endmodule

// File: tb/sim_sd_line_inhibit.sv
`timescale 1ns/1ps
module sim_sd_line_inhibit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wr = 0, cmd_uses_dat = 0, cmd_busy_rsp = 0, cmd_has_auto = 0;
    logic rsp_valid = 0, rsp_is_auto = 0, err_conflict = 0, err_ac12 = 0;
    logic dat0_in = 1, rd_xfer_active = 0, dat_io_active = 0;
    logic cmd_inhibit, dat_inhibit, dat_line_active, cmd_done, cmd_reject;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sd_line_inhibit u0 (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_uses_dat(cmd_uses_dat),
        .cmd_busy_rsp(cmd_busy_rsp), .cmd_has_auto(cmd_has_auto),
        .rsp_valid(rsp_valid), .rsp_is_auto(rsp_is_auto),
        .err_conflict(err_conflict), .err_ac12_not_issued(err_ac12),
        .dat0_in(dat0_in), .rd_xfer_active(rd_xfer_active),
        .dat_io_active(dat_io_active), .cmd_inhibit(cmd_inhibit),
        .dat_inhibit(dat_inhibit), .dat_line_active(dat_line_active),
        .cmd_done(cmd_done), .cmd_reject(cmd_reject)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic write_cmd(logic dat, logic bsy, logic aut);
        cmd_wr = 1; cmd_uses_dat = dat; cmd_busy_rsp = bsy; cmd_has_auto = aut;
        step();
        cmd_wr = 0; cmd_uses_dat = 0; cmd_busy_rsp = 0; cmd_has_auto = 0;
    endtask

    task automatic response(logic is_auto);
        rsp_valid = 1; rsp_is_auto = is_auto;
        step();
        rsp_valid = 0; rsp_is_auto = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", cmd_inhibit, 0, "cmd_inhibit");
        check("R1", dat_inhibit, 0, "dat_inhibit");
        check("R1", dat_line_active, 0, "dat_line_active");
        check("R1", cmd_done, 0, "cmd_done");
        check("R1", cmd_reject, 0, "cmd_reject");
    endtask

    task automatic t_basic();
        write_cmd(0, 0, 0);
        check("R2", cmd_inhibit, 1, "inhibit after write");
        check("R3", cmd_done, 0, "no done before response");
        step(3);
        response(0);
        check("R3", cmd_inhibit, 0, "cleared by main response");
        check("R3", cmd_done, 1, "done pulse");
        step();
        check("R12", cmd_done, 0, "done single cycle");
    endtask

    task automatic t_auto();
        write_cmd(1, 0, 1);
        step();
        response(1);
        check("R4", cmd_inhibit, 1, "auto response keeps inhibit");
        check("R4", cmd_done, 0, "no done on auto response");
        step();
        response(0);
        check("R4", cmd_inhibit, 0, "main response clears");
        check("R4", cmd_done, 1, "done on main response");
        step();
    endtask

    task automatic t_reject_busy();
        write_cmd(0, 0, 0);
        write_cmd(0, 0, 0);
        check("R6", cmd_reject, 1, "reject while inhibited");
        check("R6", cmd_inhibit, 1, "inhibit unchanged");
        step();
        check("R6", cmd_reject, 0, "reject single cycle");
        response(0);
        check("R6", cmd_inhibit, 0, "clears normally after reject");
        step();
    endtask

    task automatic t_error(logic use_ac12);
        write_cmd(0, 0, 0);
        if (use_ac12) err_ac12 = 1; else err_conflict = 1;
        step();
        err_ac12 = 0; err_conflict = 0;
        response(0);
        check("R5", cmd_inhibit, 1, "inhibit held after error");
        check("R5", cmd_done, 0, "no done after error");
        step(2);
        check("R5", cmd_inhibit, 1, "inhibit still held");
        do_reset();
        check("R5", cmd_inhibit, 0, "reset clears lock");
    endtask

    task automatic t_dat_rules();
        rd_xfer_active = 1;
        #1;
        check("R8", dat_inhibit, 1, "read transfer sets dat_inhibit");
        write_cmd(1, 0, 0);
        check("R7", cmd_reject, 1, "DAT command rejected");
        check("R7", cmd_inhibit, 0, "DAT command not accepted");
        step();
        write_cmd(0, 1, 0);
        check("R7", cmd_reject, 1, "busy command rejected");
        step();
        write_cmd(0, 0, 0);
        check("R7", cmd_reject, 0, "CMD-only accepted");
        check("R7", cmd_inhibit, 1, "CMD-only sets inhibit");
        response(0);
        rd_xfer_active = 0;
        #1;
        check("R8", dat_inhibit, 0, "dat_inhibit clears with read");
        dat_io_active = 1;
        #1;
        check("R11", dat_line_active, 1, "io activity");
        check("R8", dat_inhibit, 1, "line activity inhibits");
        dat_io_active = 0;
        #1;
        check("R11", dat_line_active, 0, "activity ends");
        step();
    endtask

    task automatic t_dat_cmd();
        write_cmd(1, 0, 0);
        check("R9", dat_inhibit, 1, "DAT command holds dat_inhibit");
        step(2);
        check("R9", dat_inhibit, 1, "held until response");
        response(0);
        check("R9", dat_inhibit, 0, "released on response");
    endtask

    task automatic t_busy();
        dat0_in = 0;
        step(3);
        write_cmd(0, 1, 0);
        step();
        response(0);
        check("R10", cmd_inhibit, 0, "cmd side free");
        check("R10", dat_inhibit, 1, "busy holds dat_inhibit");
        check("R11", dat_line_active, 1, "busy counts as activity");
        step(4);
        check("R10", dat_inhibit, 1, "busy still low");
        dat0_in = 1;
        step(2);
        check("R10", dat_inhibit, 1, "synchronizer latency");
        step();
        check("R10", dat_inhibit, 0, "released after DAT0 high");
        check("R11", dat_line_active, 0, "activity ends after busy");
    endtask

    initial begin
        step(1);
        t_reset();
        t_basic();
        t_auto();
        t_reject_busy();
        t_error(0);
        t_error(1);
        t_dat_rules();
        t_dat_cmd();
        t_busy();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule